// File: doc/BRIEF.md
# Thread Context Ring Matcher

The block decides which privilege ring of one hardware thread should take an interrupt notification. A request names a target: a format bit, a block and index that together form a 24-bit CAM identity, an ignore flag and a logical-server number. The thread's context is given as four ring words. The pool and OS rings each hold a valid bit and a stored CAM identity. The user ring holds a valid bit and a logical-server number. The physical ring holds only a valid bit, because its identity is built inside the block from a configured block id and the processor id.

A two-state controller handles each request. In `ST_IDLE` the block waits. A request strobe moves it to `ST_REPLY` (transition `T_ACCEPT`) and loads the match result. `ST_REPLY` lasts one cycle and raises the done output. From there the block returns to `ST_IDLE` (transition `T_RETIRE`), or stays in `ST_REPLY` when another strobe arrives in the same cycle (transition `T_CHAIN`). `ST_IDLE` with no strobe holds (transition `T_WAIT`). The result is a 3-bit ring code.

Top module: `thread_ring_matcher`

## Requirements
- R1: After reset, `rsp_done` is 0 and `rsp_ring` is 0.
- R2: A request sampled at a clock edge produces `rsp_done`=1 in the following cycle together with its result. With no request, `rsp_done` is 0 and `rsp_ring` keeps its last value.
- R3: When `cfg_tid8`=0, the physical identity is `{cfg_block, index}`, where index = 0x80 | `cfg_pid[6:0]` with zero upper bits.
- R4: When `cfg_tid8`=1, the physical identity uses index = 0x100 | `cfg_pid[7:0]` with zero upper bits.
- R5: The target identity is `{req_block, req_index}`, with the block in the upper bits. Stored pool and OS identities use the same layout.
- R6: For format 0 with ignore clear, the rings are tried in fixed order: physical, then pool, then OS. The first ring whose valid bit is set and whose identity equals the target wins.
- R7: A ring whose valid bit is clear never matches, even when its identity is equal to the target.
- R8: For format 0 with ignore set, the result is always 0, since logical-server delivery is not supported.
- R9: For format 1, the user ring matches only if all four hold: `os_valid` is set, `os_cam` equals the target, `user_valid` is set, and `user_ls` equals `req_ls`. In every other case the result is 0, and format 1 never yields a pool, OS or physical code.
- R10: Result codes are 0 for no match, 1 for user, 2 for OS, 3 for pool and 4 for physical. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_format | input | 1 | 0: specific target, 1: user-level event branch |
| req_block | input | BLK_W | Target block |
| req_index | input | IDX_W | Target index |
| req_ignore | input | 1 | Logical-server (low bits ignored) request |
| req_ls | input | LS_W | Requested logical-server number |
| cfg_tid8 | input | 1 | Selects an 8-bit thread id instead of a 7-bit one |
| cfg_block | input | BLK_W | Block id of this controller |
| cfg_pid | input | PID_W | Processor id of the thread |
| phys_valid | input | 1 | Physical ring valid |
| pool_valid | input | 1 | Pool ring valid |
| pool_cam | input | BLK_W+IDX_W | Pool ring stored identity |
| os_valid | input | 1 | OS ring valid |
| os_cam | input | BLK_W+IDX_W | OS ring stored identity |
| user_valid | input | 1 | User ring valid |
| user_ls | input | LS_W | User ring logical-server number |
| rsp_done | output | 1 | Result valid pulse |
| rsp_ring | output | 3 | Matched ring code |

## Verification
The assertions assume that the context words and the configuration are stable in the cycle a request is sampled. They take no other assumption about these inputs, because the result is captured at that same edge. The bench changes every input only at the falling edge, and it changes them together with the strobe. Each sweep point therefore presents one coherent context. Identities are set either equal to the target or differing in one bit, so every ring hits or misses on purpose.

// File: rtl/ring_match_pkg.sv
package ring_match_pkg;

    typedef enum logic [2:0] {
        RING_NONE = 3'd0,
        RING_USER = 3'd1,
        RING_OS   = 3'd2,
        RING_POOL = 3'd3,
        RING_PHYS = 3'd4
    } ring_code_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } match_state_e;

endpackage

// File: rtl/hw_cam_builder.sv
module hw_cam_builder #(
    parameter int BLK_W = 4,
    parameter int IDX_W = 20,
    parameter int PID_W = 10
) (
    input  logic                   tid8,
    input  logic [BLK_W-1:0]       block_id,
    input  logic [PID_W-1:0]       pid,
    output logic [BLK_W+IDX_W-1:0] hw_cam
);
    localparam int NARROW = 7;
    localparam int WIDE   = 8;

    logic [IDX_W-1:0] thread_field;

    always_comb begin
        thread_field = '0;
        if (tid8) begin
            thread_field[WIDE]       = 1'b1;
            thread_field[WIDE-1:0]   = pid[WIDE-1:0];
        end else begin
            thread_field[NARROW]     = 1'b1;
            thread_field[NARROW-1:0] = pid[NARROW-1:0];
        end
    end

    assign hw_cam = {block_id, thread_field};
endmodule

// File: rtl/ring_select.sv
module ring_select
    import ring_match_pkg::*;
#(
    parameter int CAM_W = 24,
    parameter int LS_W  = 4
) (
    input  logic             fmt,
    input  logic             ignore,
    input  logic [CAM_W-1:0] target,
    input  logic [LS_W-1:0]  ls,
    input  logic [CAM_W-1:0] hw_cam,
    input  logic             phys_valid,
    input  logic             pool_valid,
    input  logic [CAM_W-1:0] pool_cam,
    input  logic             os_valid,
    input  logic [CAM_W-1:0] os_cam,
    input  logic             user_valid,
    input  logic [LS_W-1:0]  user_ls,
    output ring_code_e       code
);
    localparam int N_CAM_RINGS = 3;

    logic [CAM_W-1:0]       ring_cam [N_CAM_RINGS];
    logic [N_CAM_RINGS-1:0] ring_vld;
    logic [N_CAM_RINGS-1:0] ring_hit;

    assign ring_cam[0] = os_cam;
    assign ring_cam[1] = pool_cam;
    assign ring_cam[2] = hw_cam;
    assign ring_vld    = {phys_valid, pool_valid, os_valid};

    for (genvar g = 0; g < N_CAM_RINGS; g++) begin : g_hit
        assign ring_hit[g] = ring_vld[g] && (ring_cam[g] == target);
    end

    always_comb begin
        code = RING_NONE;
        if (!fmt) begin
            if (!ignore) begin
                if (ring_hit[2])      code = RING_PHYS;
                else if (ring_hit[1]) code = RING_POOL;
                else if (ring_hit[0]) code = RING_OS;
            end
        end else begin
            if (ring_hit[0] && user_valid && (user_ls == ls)) code = RING_USER;
        end
    end
endmodule

// File: rtl/thread_ring_matcher.sv
module thread_ring_matcher
    import ring_match_pkg::*;
#(
    parameter int BLK_W = 4,
    parameter int IDX_W = 20,
    parameter int PID_W = 10,
    parameter int LS_W  = 4,
    localparam int CAM_W = BLK_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_format,
    input  logic [BLK_W-1:0] req_block,
    input  logic [IDX_W-1:0] req_index,
    input  logic             req_ignore,
    input  logic [LS_W-1:0]  req_ls,
    input  logic             cfg_tid8,
    input  logic [BLK_W-1:0] cfg_block,
    input  logic [PID_W-1:0] cfg_pid,
    input  logic             phys_valid,
    input  logic             pool_valid,
    input  logic [CAM_W-1:0] pool_cam,
    input  logic             os_valid,
    input  logic [CAM_W-1:0] os_cam,
    input  logic             user_valid,
    input  logic [LS_W-1:0]  user_ls,
    output logic             rsp_done,
    output logic [2:0]       rsp_ring
);
    match_state_e     state_q, state_d;
    ring_code_e       code_now;
    ring_code_e       ring_q;
    logic [CAM_W-1:0] hw_cam;
    logic [CAM_W-1:0] target;

    assign target = {req_block, req_index};

    hw_cam_builder #(.BLK_W(BLK_W), .IDX_W(IDX_W), .PID_W(PID_W)) u_cam (
        .tid8     (cfg_tid8),
        .block_id (cfg_block),
        .pid      (cfg_pid),
        .hw_cam   (hw_cam)
    );

    ring_select #(.CAM_W(CAM_W), .LS_W(LS_W)) u_sel (
        .fmt        (req_format),
        .ignore     (req_ignore),
        .target     (target),
        .ls         (req_ls),
        .hw_cam     (hw_cam),
        .phys_valid (phys_valid),
        .pool_valid (pool_valid),
        .pool_cam   (pool_cam),
        .os_valid   (os_valid),
        .os_cam     (os_cam),
        .user_valid (user_valid),
        .user_ls    (user_ls),
        .code       (code_now)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_REPLY;
            ST_REPLY: state_d = req_valid ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ring_q <= RING_NONE;
        else if (req_valid) ring_q <= code_now;
    end

    assign rsp_done = (state_q == ST_REPLY);
    assign rsp_ring = ring_q;
endmodule

// File: rtl/thread_ring_matcher_checks.sv
module thread_ring_matcher_checks #(
    parameter int BLK_W = 4,
    parameter int IDX_W = 20,
    parameter int LS_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_format,
    input logic [BLK_W-1:0]       req_block,
    input logic [IDX_W-1:0]       req_index,
    input logic                   req_ignore,
    input logic                   phys_valid,
    input logic                   pool_valid,
    input logic [BLK_W+IDX_W-1:0] pool_cam,
    input logic                   os_valid,
    input logic                   rsp_done,
    input logic [2:0]             rsp_ring
);
    assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);

    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_done && $stable(rsp_ring)));

    assert_code_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ring <= 3'd4);

    assert_ignore_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_format && req_ignore) |=> (rsp_ring == 3'd0));

    assert_user_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_format) |=> (rsp_ring <= 3'd1));

    assert_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !phys_valid && !pool_valid && !os_valid) |=> (rsp_ring == 3'd0));

    assert_pool_beats_os_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_format && !req_ignore && pool_valid &&
         pool_cam == {req_block, req_index}) |=> (rsp_ring >= 3'd3));
endmodule

bind thread_ring_matcher thread_ring_matcher_checks #(
    .BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_format (req_format),
    .req_block  (req_block),
    .req_index  (req_index),
    .req_ignore (req_ignore),
    .phys_valid (phys_valid),
    .pool_valid (pool_valid),
    .pool_cam   (pool_cam),
    .os_valid   (os_valid),
    .rsp_done   (rsp_done),
    .rsp_ring   (rsp_ring)
);

// File: tb/thread_ring_matcher_tb.sv
module thread_ring_matcher_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BLK_W = 4;
    localparam int IDX_W = 20;
    localparam int PID_W = 10;
    localparam int LS_W  = 4;
    localparam int CAM_W = BLK_W + IDX_W;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             req_valid = 0, req_format = 0, req_ignore = 0;
    logic [BLK_W-1:0] req_block = '0;
    logic [IDX_W-1:0] req_index = '0;
    logic [LS_W-1:0]  req_ls = '0;
    logic             cfg_tid8 = 0;
    logic [BLK_W-1:0] cfg_block = '0;
    logic [PID_W-1:0] cfg_pid = '0;
    logic             phys_valid = 0, pool_valid = 0, os_valid = 0, user_valid = 0;
    logic [CAM_W-1:0] pool_cam = '0, os_cam = '0;
    logic [LS_W-1:0]  user_ls = '0;
    logic             rsp_done;
    logic [2:0]       rsp_ring;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_ring_matcher #(.BLK_W(BLK_W), .IDX_W(IDX_W), .PID_W(PID_W), .LS_W(LS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_format(req_format),
        .req_block(req_block), .req_index(req_index), .req_ignore(req_ignore),
        .req_ls(req_ls), .cfg_tid8(cfg_tid8), .cfg_block(cfg_block), .cfg_pid(cfg_pid),
        .phys_valid(phys_valid), .pool_valid(pool_valid), .pool_cam(pool_cam),
        .os_valid(os_valid), .os_cam(os_cam), .user_valid(user_valid), .user_ls(user_ls),
        .rsp_done(rsp_done), .rsp_ring(rsp_ring)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [IDX_W-1:0] thread_idx(input logic t8, input logic [PID_W-1:0] p);
        if (t8) return IDX_W'(32'h100 + int'(p[7:0]));
        else    return IDX_W'(32'h80 + int'(p[6:0]));
    endfunction

    // Issue one request, then check the reply in the following cycle.
    task automatic issue(input string req, input int exp);
        @(negedge clk);
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        check({req, " done"}, int'(rsp_done), 1);
        check(req, int'(rsp_ring), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [IDX_W-1:0] tgt_idx;
        int exp;
        repeat (3) @(negedge clk);
        check("R1 done", int'(rsp_done), 0);
        check("R1 ring", int'(rsp_ring), 0);
        rst_n = 1;

        // R3 and R4: physical identity in each thread-id width, upper pid bits set.
        cfg_pid = 10'h3A5; cfg_block = 4'h6; req_block = 4'h6; phys_valid = 1;
        req_index = 20'h000A5; cfg_tid8 = 0;
        issue("R3 seven-bit identity", 4);
        cfg_tid8 = 1;
        issue("R4 seven-bit target in eight-bit mode", 0);
        req_index = 20'h001A5;
        issue("R4 eight-bit identity", 4);
        cfg_tid8 = 0;
        issue("R3 eight-bit target in seven-bit mode", 0);

        // R2: with no request the reply stays low and the code holds.
        @(negedge clk);
        check("R2 idle done", int'(rsp_done), 0);
        check("R2 idle hold", int'(rsp_ring), 0);

        // Sweep: R5 R6 R7 R8 R9 R10.
        for (int t8 = 0; t8 < 2; t8++) begin
            for (int v = 0; v < 16; v++) begin
                for (int m = 0; m < 16; m++) begin
                    for (int f = 0; f < 4; f++) begin
                        @(negedge clk);
                        cfg_tid8   = t8[0];
                        cfg_pid    = PID_W'(v * 37 + m * 5 + 3);
                        tgt_idx    = thread_idx(cfg_tid8, cfg_pid);
                        req_block  = 4'h9;
                        req_index  = tgt_idx;
                        cfg_block  = m[0] ? 4'h9 : 4'h8;
                        pool_cam   = m[1] ? {4'h9, tgt_idx} : {4'h9, tgt_idx ^ 20'h1};
                        os_cam     = m[2] ? {4'h9, tgt_idx} : {4'h1, tgt_idx};
                        req_ls     = 4'hC;
                        user_ls    = m[3] ? 4'hC : 4'hD;
                        phys_valid = v[0]; pool_valid = v[1];
                        os_valid   = v[2]; user_valid = v[3];
                        req_format = f[0]; req_ignore = f[1];
                        if (!f[0]) begin
                            if (f[1])              exp = 0;
                            else if (v[0] && m[0]) exp = 4;
                            else if (v[1] && m[1]) exp = 3;
                            else if (v[2] && m[2]) exp = 2;
                            else                   exp = 0;
                        end else begin
                            exp = (v[2] && m[2] && v[3] && m[3]) ? 1 : 0;
                        end
                        req_valid = 1;
                        @(negedge clk);
                        req_valid = 0;
                        check("R2 sweep done", int'(rsp_done), 1);
                        if (!f[0] && f[1])  check("R8 ignore", int'(rsp_ring), exp);
                        else if (f[0])      check("R9 user ring", int'(rsp_ring), exp);
                        else if (v == 0)    check("R7 no valid", int'(rsp_ring), exp);
                        else                check("R6 R5 R10 order", int'(rsp_ring), exp);
                    end
                end
            end
        end

        // R2: back-to-back requests keep done high and update the code.
        @(negedge clk);
        req_format = 0; req_ignore = 0; phys_valid = 0; os_valid = 1; pool_valid = 1;
        os_cam = {req_block, req_index}; pool_cam = '0; req_valid = 1;
        @(negedge clk);
        check("R2 chain first", int'(rsp_ring), 2);
        pool_cam = {req_block, req_index};
        @(negedge clk);
        req_valid = 0;
        check("R2 chain done", int'(rsp_done), 1);
        check("R2 chain second", int'(rsp_ring), 3);
        @(negedge clk);
        check("R2 chain end", int'(rsp_done), 0);
        check("R2 chain hold", int'(rsp_ring), 3);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule